// File: doc/BRIEF.md
# Power-Down Mode Controller

This block decides when a small processor subsystem may stop its clocks and when it must start them again. Instruction execution sends a one-cycle sleep request. A standby-select bit chooses between two low-power states. In the light state only the processor clock stops. In the deep state the processor clock, the peripheral clock and the oscillator all stop. Each state has its own set of wake sources. Leaving the deep state also waits for the oscillator to settle: a counter counts ticks from a free-running reference, because the main oscillator is off during that time.

Separately from the power-down states, five stop bits gate the clocks of five peripheral modules one at a time. Bit 0 is the multiplier, bit 1 the divider, bit 2 the free-running timer, bit 3 the serial port and bit 4 the DMA controller. When a module is stopped, its pins receive a reset pulse. Its registers receive a reset pulse too, except in the modules that keep their register contents. The DMA global enable is held cleared while the DMA module is stopped.

Each wake produces a one-cycle event carrying a 2-bit source code, which the exception sequencer outside this block uses to resume execution.

Top module: `pdc_top`

## Requirements
- R1: After `rst_n` is released, the controller is running: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, `wake_vld` and `stby_err` are 0.
- R2: A `sleep_req` sampled while running keeps all enables at their running values for ENTRY_CYC (default 3) clock cycles after the sampling edge; they change at the next edge. A `sleep_req` seen in any other state is ignored.
- R3: In sleep (request taken with `standby_sel`=0), `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R4: In sleep, any of `irq`, `nmi`, `dma_addr_err` or `sys_rst` at a clock edge returns the block to running at that edge. The edge also emits a wake event whose code reflects the highest-priority source present. Codes are: 3 = reset, 1 = NMI, 2 = DMA address error, 0 = interrupt. Priority runs reset > NMI > DMA error > interrupt.
- R5: In standby (request taken with `standby_sel`=1 and `dma_me_in`=0), `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R6: In standby, `irq` and `dma_addr_err` have no effect: all enables stay 0 and no wake event appears.
- R7: In standby, `nmi` or `sys_rst` at an edge raises `osc_en` at that edge. `cpu_clk_en` and `per_clk_en` stay 0 until STAB_TICKS `ref_tick` pulses have been counted. At the edge that samples the last tick, running resumes and a wake event appears with code 3 for reset or 1 for NMI.
- R8: A request with `standby_sel`=1 while `dma_me_in`=1 enters sleep instead of standby and sets `stby_err` at the request edge. The next accepted request clears `stby_err`.
- R9: `wake_vld` is high for exactly one clock cycle per wake.
- R10: `mod_clk_en[i]` is 1 exactly when `per_clk_en` is 1 and `mstop[i]` is 0 (bit 0 multiplier, 1 divider, 2 timer, 3 serial, 4 DMA).
- R11: A 0-to-1 change of `mstop[i]` gives a one-cycle pulse on `mod_pin_rst[i]` in the cycle after the edge that sees it. The same pulse appears on `mod_reg_rst[i]`, except for bits 0, 1 and 4, whose registers are kept.
- R12: `dma_me_clr` is 1 while `mstop[4]` is 1 or while the oscillator is stopped in standby.
- R13: While `sys_rst` is 1, `por_sel` follows `nmi` and `mrst_sel` follows its inverse. Both are 0 when `sys_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| ref_tick | input | 1 | One-cycle tick from the free-running reference |
| sleep_req | input | 1 | Sleep request pulse from instruction execution |
| standby_sel | input | 1 | 1 selects standby, 0 selects sleep |
| dma_me_in | input | 1 | Current DMA global enable |
| mstop | input | 5 | Per-module stop bits |
| irq | input | 1 | Interrupt request |
| nmi | input | 1 | Non-maskable interrupt; also picks the reset type |
| dma_addr_err | input | 1 | DMA address error |
| sys_rst | input | 1 | System reset request |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| mod_clk_en | output | 5 | Per-module clock enables |
| mod_pin_rst | output | 5 | Per-module pin reset pulses |
| mod_reg_rst | output | 5 | Per-module register reset pulses |
| dma_me_clr | output | 1 | Forces the DMA global enable to 0 |
| wake_vld | output | 1 | One-cycle wake event |
| wake_code | output | 2 | Wake source code |
| stby_err | output | 1 | Standby refused because DMA was enabled |
| por_sel | output | 1 | Power-on reset selected |
| mrst_sel | output | 1 | Manual reset selected |

## Verification
The bench builds the block with STAB_TICKS set to 6 and ENTRY_CYC left at 3. At that count the whole oscillator wait fits in a few cycles, so the bench can check the hold before the last tick, the idle cycles with no tick, and the release on the final tick. The default register-keep mask is kept, so the modules that get a register reset and the modules that keep their registers both appear among the five stop bits. A vector table walks every wake source and several mixed combinations through sleep to check the code priority.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_ENTER = 3'd1,
      ST_SLEEP = 3'd2,
      ST_STBY  = 3'd3,
      ST_STAB  = 3'd4
   } pdc_state_e;

   typedef enum logic [1:0] {
      WK_IRQ    = 2'd0,
      WK_NMI    = 2'd1,
      WK_DMAERR = 2'd2,
      WK_RESET  = 2'd3
   } wake_code_e;

   function automatic wake_code_e pick_wake(input logic rst_i, input logic nmi_i,
                                            input logic derr_i);
      if (rst_i)       return WK_RESET;
      else if (nmi_i)  return WK_NMI;
      else if (derr_i) return WK_DMAERR;
      else             return WK_IRQ;
   endfunction

endpackage

// File: rtl/pdc_stab_timer.sv
module pdc_stab_timer #(
   parameter int STAB_TICKS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   output logic done
);
   localparam int CW = $clog2(STAB_TICKS + 1);

   generate
      if (STAB_TICKS < 1) begin : g_bad_ticks
         $error("STAB_TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          busy;

   assign done = busy && tick && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (load) begin
         cnt  <= CW'(STAB_TICKS);
         busy <= 1'b1;
      end else if (busy && tick) begin
         if (cnt == CW'(1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt - CW'(1);
         end
      end
   end

   AST_STAB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt != '0)); // R7

endmodule

// File: rtl/pdc_mod_gate.sv
module pdc_mod_gate #(
   parameter bit KEEP_REGS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop,
   input  logic per_en,
   output logic clk_en,
   output logic pin_rst,
   output logic reg_rst
);
   logic stop_q;

   assign clk_en = per_en & ~stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q  <= 1'b1;
         pin_rst <= 1'b0;
      end else begin
         stop_q  <= stop;
         pin_rst <= stop & ~stop_q;
      end
   end

   generate
      if (KEEP_REGS) begin : g_keep
         assign reg_rst = 1'b0;
      end else begin : g_init
         assign reg_rst = pin_rst;
      end
   endgenerate

   AST_PIN_RST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rst |=> !pin_rst); // R11

   AST_PIN_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rst |-> stop_q); // R11

endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm
   import pdc_pkg::*;
#(
   parameter int ENTRY_CYC = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       standby_sel,
   input  logic       dma_me_in,
   input  logic       irq,
   input  logic       nmi,
   input  logic       dma_addr_err,
   input  logic       sys_rst,
   input  logic       stab_done,
   output logic       stab_load,
   output logic       cpu_en,
   output logic       per_en,
   output logic       osc_en,
   output logic       in_stby,
   output logic       wake_vld,
   output logic [1:0] wake_code,
   output logic       stby_err
);
   localparam int EW = $clog2(ENTRY_CYC) + 1;

   generate
      if (ENTRY_CYC < 1) begin : g_bad_entry
         $error("ENTRY_CYC must be at least 1");
      end
   endgenerate

   pdc_state_e    state;
   logic [EW-1:0] ent_cnt;
   logic          go_stby;
   wake_code_e    pend_code;
   logic          sleep_wake;
   logic          stby_wake;

   assign sleep_wake = irq | nmi | dma_addr_err | sys_rst;
   assign stby_wake  = nmi | sys_rst;
   assign stab_load  = (state == ST_STBY) && stby_wake;

   assign cpu_en  = (state == ST_RUN) || (state == ST_ENTER);
   assign per_en  = cpu_en || (state == ST_SLEEP);
   assign osc_en  = (state != ST_STBY);
   assign in_stby = (state == ST_STBY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         ent_cnt   <= '0;
         go_stby   <= 1'b0;
         pend_code <= WK_IRQ;
         wake_vld  <= 1'b0;
         wake_code <= 2'd0;
         stby_err  <= 1'b0;
      end else begin
         wake_vld <= 1'b0;
         case (state)
            ST_RUN: begin
               if (sleep_req) begin
                  state    <= ST_ENTER;
                  ent_cnt  <= '0;
                  go_stby  <= standby_sel & ~dma_me_in;
                  stby_err <= standby_sel & dma_me_in;
               end
            end
            ST_ENTER: begin
               if (ent_cnt == EW'(ENTRY_CYC - 1)) begin
                  state <= go_stby ? ST_STBY : ST_SLEEP;
               end else begin
                  ent_cnt <= ent_cnt + EW'(1);
               end
            end
            ST_SLEEP: begin
               if (sleep_wake) begin
                  state     <= ST_RUN;
                  wake_vld  <= 1'b1;
                  wake_code <= pick_wake(sys_rst, nmi, dma_addr_err);
               end
            end
            ST_STBY: begin
               if (stby_wake) begin
                  state     <= ST_STAB;
                  pend_code <= sys_rst ? WK_RESET : WK_NMI;
               end
            end
            ST_STAB: begin
               if (stab_done) begin
                  state     <= ST_RUN;
                  wake_vld  <= 1'b1;
                  wake_code <= pend_code;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   AST_ENTRY_KEEPS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_req) |=> cpu_en); // R2

   AST_SLEEP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP && sleep_wake) |=> (wake_vld && state == ST_RUN)); // R4

   AST_STBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STBY && !stby_wake) |=> (state == ST_STBY && !wake_vld)); // R6

   AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_req && standby_sel && dma_me_in)
      |=> (stby_err && !go_stby)); // R8

   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_vld |=> !wake_vld); // R9

endmodule

// File: rtl/pdc_top.sv
module pdc_top
   import pdc_pkg::*;
#(
   parameter int          ENTRY_CYC  = 3,
   parameter int          STAB_TICKS = 1024,
   parameter int          NUM_MOD    = 5,
   parameter int          DMA_IDX    = 4,
   parameter logic [4:0]  KEEP_MASK  = 5'b10011
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_tick,
   input  logic       sleep_req,
   input  logic       standby_sel,
   input  logic       dma_me_in,
   input  logic [4:0] mstop,
   input  logic       irq,
   input  logic       nmi,
   input  logic       dma_addr_err,
   input  logic       sys_rst,
   output logic       cpu_clk_en,
   output logic       per_clk_en,
   output logic       osc_en,
   output logic [4:0] mod_clk_en,
   output logic [4:0] mod_pin_rst,
   output logic [4:0] mod_reg_rst,
   output logic       dma_me_clr,
   output logic       wake_vld,
   output logic [1:0] wake_code,
   output logic       stby_err,
   output logic       por_sel,
   output logic       mrst_sel
);
   generate
      if (NUM_MOD != 5) begin : g_bad_nmod
         $error("NUM_MOD must match the 5-bit module ports");
      end
      if (DMA_IDX < 0 || DMA_IDX >= NUM_MOD) begin : g_bad_dma
         $error("DMA_IDX out of range");
      end
   endgenerate

   logic stab_load;
   logic stab_done;
   logic in_stby;

   pdc_mode_fsm #(.ENTRY_CYC(ENTRY_CYC)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_req    (sleep_req),
      .standby_sel  (standby_sel),
      .dma_me_in    (dma_me_in),
      .irq          (irq),
      .nmi          (nmi),
      .dma_addr_err (dma_addr_err),
      .sys_rst      (sys_rst),
      .stab_done    (stab_done),
      .stab_load    (stab_load),
      .cpu_en       (cpu_clk_en),
      .per_en       (per_clk_en),
      .osc_en       (osc_en),
      .in_stby      (in_stby),
      .wake_vld     (wake_vld),
      .wake_code    (wake_code),
      .stby_err     (stby_err)
   );

   pdc_stab_timer #(.STAB_TICKS(STAB_TICKS)) u_stab (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (stab_load),
      .tick  (ref_tick),
      .done  (stab_done)
   );

   for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
      pdc_mod_gate #(.KEEP_REGS(KEEP_MASK[i])) u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .stop    (mstop[i]),
         .per_en  (per_clk_en),
         .clk_en  (mod_clk_en[i]),
         .pin_rst (mod_pin_rst[i]),
         .reg_rst (mod_reg_rst[i])
      );
   end

   assign dma_me_clr = mstop[DMA_IDX] | in_stby;
   assign por_sel    = sys_rst & nmi;
   assign mrst_sel   = sys_rst & ~nmi;

   AST_STBY_DMA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en) |-> dma_me_clr); // R12

   AST_GATED_IN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en) |-> (mod_clk_en == '0 && !cpu_clk_en)); // R10

endmodule

// File: tb/sim_pdc_top.sv
module sim_pdc_top;
   localparam int STAB = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0, sleep_req = 1'b0, standby_sel = 1'b0, dma_me_in = 1'b0;
   logic [4:0] mstop = 5'b0;
   logic       irq = 1'b0, nmi = 1'b0, dma_addr_err = 1'b0, sys_rst = 1'b0;
   logic       cpu_clk_en, per_clk_en, osc_en, dma_me_clr, wake_vld, stby_err;
   logic       por_sel, mrst_sel;
   logic [4:0] mod_clk_en, mod_pin_rst, mod_reg_rst;
   logic [1:0] wake_code;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   pdc_top #(.STAB_TICKS(STAB)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sleep_req(sleep_req),
      .standby_sel(standby_sel), .dma_me_in(dma_me_in), .mstop(mstop),
      .irq(irq), .nmi(nmi), .dma_addr_err(dma_addr_err), .sys_rst(sys_rst),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
      .mod_clk_en(mod_clk_en), .mod_pin_rst(mod_pin_rst), .mod_reg_rst(mod_reg_rst),
      .dma_me_clr(dma_me_clr), .wake_vld(wake_vld), .wake_code(wake_code),
      .stby_err(stby_err), .por_sel(por_sel), .mrst_sel(mrst_sel)
   );

   // {irq, nmi, dma_err, sys_rst, expected code}
   localparam logic [5:0] WVEC [8] = '{
      {4'b1000, 2'd0}, {4'b0100, 2'd1}, {4'b0010, 2'd2}, {4'b0001, 2'd3},
      {4'b1010, 2'd2}, {4'b1111, 2'd3}, {4'b0110, 2'd1}, {4'b1100, 2'd1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic request(input logic stby);
      standby_sel = stby;
      sleep_req   = 1'b1;
      step();
      sleep_req   = 1'b0;
      standby_sel = 1'b0;
   endtask

   task automatic enter(input logic stby);
      request(stby);
      step(); step(); step();
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 cpu_clk_en", cpu_clk_en, 1);
      check("R1 per_clk_en", per_clk_en, 1);
      check("R1 osc_en", osc_en, 1);
      check("R1 wake_vld", wake_vld, 0);
      check("R1 stby_err", stby_err, 0);
      check("R1 mod_clk_en", mod_clk_en, 5'h1f);

      // R2 entry delay then R3 sleep levels
      request(1'b0);
      check("R2 hold cycle1", cpu_clk_en, 1);
      step(); check("R2 hold cycle2", cpu_clk_en, 1);
      step(); check("R2 hold cycle3", cpu_clk_en, 1);
      step(); check("R3 cpu off", cpu_clk_en, 0);
      check("R3 per on", per_clk_en, 1);
      check("R3 osc on", osc_en, 1);
      check("R10 modules in sleep", mod_clk_en, 5'h1f);
      // R2 request ignored while asleep
      request(1'b1);
      step(); step(); step(); step();
      check("R2 ignored in sleep per", per_clk_en, 1);
      check("R2 ignored in sleep osc", osc_en, 1);
      irq = 1'b1; step(); irq = 1'b0;
      check("R4 irq wakes", cpu_clk_en, 1);
      step();

      // R4 vector walk through sleep
      for (int i = 0; i < 8; i++) begin
         enter(1'b0);
         {irq, nmi, dma_addr_err, sys_rst} = WVEC[i][5:2];
         step();
         {irq, nmi, dma_addr_err, sys_rst} = 4'b0;
         check($sformatf("R4 vec%0d wake_vld", i), wake_vld, 1);
         check($sformatf("R4 vec%0d code", i), wake_code, WVEC[i][1:0]);
         check($sformatf("R4 vec%0d cpu", i), cpu_clk_en, 1);
         step();
         check($sformatf("R9 vec%0d pulse end", i), wake_vld, 0);
      end

      // R5 / R6 / R7 standby
      enter(1'b1);
      check("R5 cpu off", cpu_clk_en, 0);
      check("R5 per off", per_clk_en, 0);
      check("R5 osc off", osc_en, 0);
      check("R12 dma clr in standby", dma_me_clr, 1);
      check("R10 modules off in standby", mod_clk_en, 5'h00);
      irq = 1'b1; dma_addr_err = 1'b1;
      for (int k = 0; k < 4; k++) begin
         step();
         check("R6 osc stays off", osc_en, 0);
         check("R6 no wake", wake_vld, 0);
      end
      irq = 1'b0; dma_addr_err = 1'b0;
      step();
      check("R6 cpu still off", cpu_clk_en, 0);
      nmi = 1'b1; step(); nmi = 1'b0;
      check("R7 osc restarts", osc_en, 1);
      check("R7 cpu held", cpu_clk_en, 0);
      check("R12 clr released", dma_me_clr, 0);
      for (int k = 0; k < STAB - 1; k++) begin
         ref_tick = 1'b1; step(); ref_tick = 1'b0;
         step();
         check("R7 waiting", per_clk_en, 0);
      end
      step(); step();
      check("R7 idle no tick", cpu_clk_en, 0);
      ref_tick = 1'b1; step(); ref_tick = 1'b0;
      check("R7 resume", cpu_clk_en, 1);
      check("R7 wake", wake_vld, 1);
      check("R7 nmi code", wake_code, 1);
      step();
      check("R9 standby pulse end", wake_vld, 0);

      // R7 reset wakes standby with code 3
      enter(1'b1);
      sys_rst = 1'b1; nmi = 1'b1; step(); sys_rst = 1'b0; nmi = 1'b0;
      for (int k = 0; k < STAB; k++) begin
         ref_tick = 1'b1; step(); ref_tick = 1'b0;
      end
      check("R7 reset code", wake_code, 3);
      check("R7 reset wake", wake_vld, 1);
      step();

      // R8 refusal
      dma_me_in = 1'b1;
      request(1'b1);
      check("R8 err set", stby_err, 1);
      step(); step(); step();
      check("R8 sleep not standby", per_clk_en, 1);
      check("R8 osc kept", osc_en, 1);
      irq = 1'b1; step(); irq = 1'b0;
      step();
      dma_me_in = 1'b0;
      request(1'b0);
      check("R8 err cleared", stby_err, 0);
      step(); step(); step();
      irq = 1'b1; step(); irq = 1'b0;
      step();

      // R10 / R11 / R12 module stop
      mstop[2] = 1'b1; step();
      check("R11 timer pin rst", mod_pin_rst, 5'b00100);
      check("R11 timer reg rst", mod_reg_rst, 5'b00100);
      check("R10 timer gated", mod_clk_en, 5'b11011);
      step();
      check("R11 timer pulse end", mod_pin_rst, 5'b0);
      mstop[0] = 1'b1; step();
      check("R11 mult pin rst", mod_pin_rst, 5'b00001);
      check("R11 mult regs kept", mod_reg_rst, 5'b0);
      step();
      mstop[4] = 1'b1; step();
      check("R11 dma pin rst", mod_pin_rst, 5'b10000);
      check("R11 dma regs kept", mod_reg_rst, 5'b0);
      check("R12 dma stop clr", dma_me_clr, 1);
      mstop[3] = 1'b1; step();
      check("R11 serial reg rst", mod_reg_rst, 5'b01000);
      mstop = 5'b0; step();
      check("R10 all restored", mod_clk_en, 5'h1f);
      check("R11 no pulse on clear", mod_pin_rst, 5'b0);
      check("R12 clr low", dma_me_clr, 0);

      // R13 reset type select
      sys_rst = 1'b1; nmi = 1'b1; #1;
      check("R13 por", {por_sel, mrst_sel}, 2'b10);
      nmi = 1'b0; #1;
      check("R13 manual", {por_sel, mrst_sel}, 2'b01);
      sys_rst = 1'b0; #1;
      check("R13 none", {por_sel, mrst_sel}, 2'b00);
      step();
      check("R13 run unaffected", cpu_clk_en, 1);

      finish_run();
   end
endmodule